// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the operand-steering and interlock control of a five-stage in-order integer pipeline whose stages run fetch, decode, execute, memory, writeback. Each cycle it looks at the source register numbers of the instructions in decode, execute and memory. It compares them with the destination numbers, write enables and load flags held in the older stage registers. From those comparisons it produces two things: bypass selects for the two execute operands and for the store-data operand of the memory stage, and a stall request that freezes fetch and decode while a bubble enters execute.

A strap input picks one of two modes. With bypassing on, results are taken from the memory-stage and writeback-stage register outputs. Only a load followed directly by a consumer has to wait, and it waits one cycle. With bypassing off, every select stays on the register file, and a consumer waits until its producer reaches writeback. In that stage the register file hands the value being written straight to a reader of the same register. The block is purely combinational. The stage registers, datapath multiplexers and memories belong to the surrounding pipeline.

Top module: `hz_fwd_unit`

## Requirements
- R1: Execute operand selects use the encoding 0 = register file, 1 = memory-stage result, 2 = writeback-stage result; the value 3 never appears. With bypassing on, an execute source that matches a writing memory-stage destination selects 1.
- R2: With bypassing on, an execute source that matches a writing writeback-stage destination, and no writing memory-stage destination, selects 2.
- R3: When both the memory and the writeback stage write the register an execute source reads, the memory-stage result (1) is chosen.
- R4: Register 0 and stages whose write enable is low are never hazard sources: they cause neither a bypass select nor a stall, even when the load flag is set.
- R5: With bypassing on, a load in execute whose destination matches either decode source raises the hold and the bubble outputs, and both are always equal.
- R6: With bypassing on, a non-load producer in execute never causes a stall.
- R7: With bypassing off, all three selects stay 0, and a decode source matching a writing destination in execute or memory raises the stall.
- R8: A producer that has reached writeback never causes a stall in either mode, because the register file passes the written value to a same-cycle reader.
- R9: With bypassing on, the memory-stage store-data select is 1 when its source matches a writing, non-zero writeback destination, and is 0 otherwise.
- R10: In a running pipeline, a consumer directly behind its producer is delayed 2 cycles with bypassing off, 1 cycle behind a load with bypassing on, and 0 cycles behind an ALU result with bypassing on. When it reaches execute it selects 1 (ALU case) or 2 (load case).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | Mode strap: 1 enables bypass paths |
| id_src_a | input | RW | First source register of the decode-stage instruction |
| id_src_b | input | RW | Second source register of the decode-stage instruction |
| ex_src_a | input | RW | First source register of the execute-stage instruction |
| ex_src_b | input | RW | Second source register (also store data) of the execute-stage instruction |
| ex_dst | input | RW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_store_src | input | RW | Store-data source register of the memory-stage instruction |
| wb_dst | input | RW | Destination register of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| ex_sel_a | output | 2 | Bypass select for execute operand A |
| ex_sel_b | output | 2 | Bypass select for execute operand B |
| mem_sel_store | output | 1 | Store data taken from the writeback-stage result |
| hold_fd | output | 1 | Freeze the fetch and decode stage registers |
| bubble_ex | output | 1 | Load a nop into the execute stage register |

## Verification
Every output is a combinational function of the stage fields present in the same cycle. The bench therefore applies each table vector or pipeline state shortly after a clock edge and samples one nanosecond later, within the same cycle, with no register in between. The pipeline-run checks model the stage registers in the bench and advance them only at rising edges, using the hold decision sampled in the cycle before that edge. Stall counts are tallied per cycle, and the execute-stage select is captured in the first cycle in which the consumer occupies execute.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source encoding shared by both execute selects
  typedef enum logic [1:0] {
    OPSEL_REGFILE = 2'd0,
    OPSEL_MEM     = 2'd1,
    OPSEL_WB      = 2'd2
  } opsel_e;

  localparam int unsigned NUM_ID_SRC = 2;
endpackage

// File: rtl/hz_exe_sel.sv
module hz_exe_sel #(
  parameter int unsigned RW = 5
) (
  input  logic           fwd_on,
  input  logic [RW-1:0]  src,
  input  logic [RW-1:0]  mem_dst,
  input  logic           mem_wr,
  input  logic [RW-1:0]  wb_dst,
  input  logic           wb_wr,
  output hz_pkg::opsel_e sel,
  output logic           mem_hit,
  output logic           wb_hit
);
  // A producer counts only when it writes and its destination is non-zero
  function automatic logic producer_hit(logic [RW-1:0] s, logic [RW-1:0] d, logic w);
    return w && (d != '0) && (d == s);
  endfunction

  assign mem_hit = fwd_on && producer_hit(src, mem_dst, mem_wr);
  assign wb_hit  = fwd_on && producer_hit(src, wb_dst, wb_wr);

  // Younger result wins
  always_comb begin
    if (mem_hit)     sel = hz_pkg::OPSEL_MEM;
    else if (wb_hit) sel = hz_pkg::OPSEL_WB;
    else             sel = hz_pkg::OPSEL_REGFILE;
  end
endmodule

// File: rtl/hz_store_bypass.sv
module hz_store_bypass #(
  parameter int unsigned RW = 5
) (
  input  logic          fwd_on,
  input  logic [RW-1:0] store_src,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic          take_wb
);
  function automatic logic store_hit(logic [RW-1:0] s, logic [RW-1:0] d, logic w);
    return w && (d != '0) && (d == s);
  endfunction

  assign take_wb = fwd_on && store_hit(store_src, wb_dst, wb_wr);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int unsigned RW   = 5,
  parameter int unsigned NSRC = hz_pkg::NUM_ID_SRC
) (
  input  logic                     fwd_on,
  input  logic [NSRC-1:0][RW-1:0]  id_src,
  input  logic [RW-1:0]            ex_dst,
  input  logic                     ex_wr,
  input  logic                     ex_load,
  input  logic [RW-1:0]            mem_dst,
  input  logic                     mem_wr,
  output logic                     load_use_hit,
  output logic                     raw_wait_hit,
  output logic                     stall
);
  function automatic logic dep_hit(logic [RW-1:0] s, logic [RW-1:0] d, logic w);
    return w && (d != '0) && (d == s);
  endfunction

  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit_ex[i]  = dep_hit(id_src[i], ex_dst, ex_wr);
    assign hit_mem[i] = dep_hit(id_src[i], mem_dst, mem_wr);
  end

  // Bypassing on: only load data is late (ready at the end of memory)
  assign load_use_hit = fwd_on && ex_load && (|hit_ex);
  // Bypassing off: wait until the producer reaches writeback
  assign raw_wait_hit = !fwd_on && ((|hit_ex) || (|hit_mem));
  assign stall        = load_use_hit || raw_wait_hit;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int unsigned RW = 5
) (
  input  logic          fwd_en,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [RW-1:0] mem_store_src,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          mem_sel_store,
  output logic          hold_fd,
  output logic          bubble_ex
);
  localparam int unsigned NSRC = hz_pkg::NUM_ID_SRC;

  hz_pkg::opsel_e            sel_e [NSRC];
  logic [NSRC-1:0]           ex_mem_hit;
  logic [NSRC-1:0]           ex_wb_hit;
  logic [NSRC-1:0][RW-1:0]   ex_src_v;
  logic [NSRC-1:0][RW-1:0]   id_src_v;
  logic                      load_use_hit;
  logic                      raw_wait_hit;
  logic                      stall_req;

  assign ex_src_v = {ex_src_b, ex_src_a};
  assign id_src_v = {id_src_b, id_src_a};

  for (genvar i = 0; i < NSRC; i++) begin : g_opnd
    hz_exe_sel #(.RW(RW)) sel_i (
      .fwd_on  (fwd_en),
      .src     (ex_src_v[i]),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_wr),
      .sel     (sel_e[i]),
      .mem_hit (ex_mem_hit[i]),
      .wb_hit  (ex_wb_hit[i])
    );
  end

  hz_store_bypass #(.RW(RW)) stb_i (
    .fwd_on    (fwd_en),
    .store_src (mem_store_src),
    .wb_dst    (wb_dst),
    .wb_wr     (wb_wr),
    .take_wb   (mem_sel_store)
  );

  hz_interlock #(.RW(RW), .NSRC(NSRC)) ilk_i (
    .fwd_on       (fwd_en),
    .id_src       (id_src_v),
    .ex_dst       (ex_dst),
    .ex_wr        (ex_wr),
    .ex_load      (ex_load),
    .mem_dst      (mem_dst),
    .mem_wr       (mem_wr),
    .load_use_hit (load_use_hit),
    .raw_wait_hit (raw_wait_hit),
    .stall        (stall_req)
  );

  assign ex_sel_a  = sel_e[0];
  assign ex_sel_b  = sel_e[1];
  assign hold_fd   = stall_req;
  assign bubble_ex = stall_req;
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int unsigned RW = 5
) (
  input logic          fwd_en,
  input logic [RW-1:0] ex_src_a,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_load,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          mem_sel_store,
  input logic          hold_fd,
  input logic          bubble_ex,
  input logic [1:0]    ex_mem_hit,
  input logic [1:0]    ex_wb_hit,
  input logic          load_use_hit,
  input logic          raw_wait_hit
);
  always_comb begin
    // R5: freeze and bubble come as a pair
    a_r5_hold_is_bubble: assert (hold_fd == bubble_ex)
      else $error("hold and bubble differ");
    // R1: unused select code never produced
    a_r1_sel_legal: assert ((ex_sel_a != 2'd3) && (ex_sel_b != 2'd3))
      else $error("illegal operand select");
    // R7: no-bypass mode keeps every select on the register file
    a_r7_nofwd_quiet: assert (fwd_en || ((ex_sel_a == 2'd0) && (ex_sel_b == 2'd0) && !mem_sel_store))
      else $error("bypass while disabled");
    // R4: register 0 source is never bypassed
    a_r4_zero_src: assert ((ex_src_a != '0) || (ex_sel_a == 2'd0))
      else $error("register 0 bypassed");
    // R6: with bypassing on, only a load in execute stalls
    a_r6_alu_no_stall: assert (!fwd_en || ex_load || !hold_fd)
      else $error("stall without load");
    // R8: a stall always has a producer in execute or memory
    a_r8_wb_no_stall: assert (!hold_fd || (ex_wr && ex_dst != '0) || (mem_wr && mem_dst != '0))
      else $error("stall without live producer");
    // R7: the two interlock causes are mode-exclusive
    a_r7_cause_exclusive: assert (!(load_use_hit && raw_wait_hit))
      else $error("both interlock causes");
    // R3: a memory hit always yields the memory select on operand A
    a_r3_mem_over_wb: assert (!ex_mem_hit[0] || (ex_sel_a == 2'd1))
      else $error("memory hit lost priority");
    // R2: a lone writeback hit yields the writeback select on operand B
    a_r2_wb_sel: assert (!(ex_wb_hit[1] && !ex_mem_hit[1]) || (ex_sel_b == 2'd2))
      else $error("writeback hit not selected");
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.RW(RW)) chk_i (
  .fwd_en        (fwd_en),
  .ex_src_a      (ex_src_a),
  .ex_dst        (ex_dst),
  .ex_wr         (ex_wr),
  .ex_load       (ex_load),
  .mem_dst       (mem_dst),
  .mem_wr        (mem_wr),
  .ex_sel_a      (ex_sel_a),
  .ex_sel_b      (ex_sel_b),
  .mem_sel_store (mem_sel_store),
  .hold_fd       (hold_fd),
  .bubble_ex     (bubble_ex),
  .ex_mem_hit    (ex_mem_hit),
  .ex_wb_hit     (ex_wb_hit),
  .load_use_hit  (load_use_hit),
  .raw_wait_hit  (raw_wait_hit)
);

// File: tb/hz_fwd_unit_tb_top.sv
module hz_fwd_unit_tb_top;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          fwd_en = 1'b0;
  logic [RW-1:0] id_src_a = '0, id_src_b = '0, ex_src_a = '0, ex_src_b = '0;
  logic [RW-1:0] ex_dst = '0, mem_dst = '0, mem_store_src = '0, wb_dst = '0;
  logic          ex_wr = 1'b0, ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
  logic [1:0]    ex_sel_a, ex_sel_b;
  logic          mem_sel_store, hold_fd, bubble_ex;

  hz_fwd_unit #(.RW(RW)) dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input int req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic fwd; logic [4:0] ida, idb, exa, exb, exd; logic exwr, exld;
    logic [4:0] memd; logic memwr; logic [4:0] mst, wbd; logic wbwr;
    logic [1:0] sa, sb; logic ms, st; logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,3,0,0,0,0,3,1,0,0,0,1,0,0,0,1},  // R1 memory bypass
    '{1,0,0,0,4,0,0,0,0,0,0,4,1,0,2,0,0,2},  // R2 writeback bypass B
    '{1,0,0,3,3,0,0,0,3,1,0,3,1,1,1,0,0,3},  // R3 memory beats writeback
    '{1,0,0,0,0,0,0,0,0,1,0,0,1,0,0,0,0,4},  // R4 register 0 destinations
    '{1,0,0,3,3,0,0,0,3,0,0,3,0,0,0,0,0,4},  // R4 writes disabled
    '{1,7,0,0,0,7,1,1,0,0,0,0,0,0,0,0,1,5},  // R5 load-use on A
    '{1,0,7,0,0,7,1,1,0,0,0,0,0,0,0,0,1,5},  // R5 load-use on B
    '{1,7,7,0,0,7,1,0,0,0,0,0,0,0,0,0,0,6},  // R6 ALU producer, no stall
    '{0,7,0,3,0,7,1,0,3,1,0,0,0,0,0,0,1,7},  // R7 ex match, selects held
    '{0,0,9,0,0,0,0,0,9,1,0,0,0,0,0,0,1,7},  // R7 memory match stalls
    '{0,9,0,0,0,0,0,0,0,0,0,9,1,0,0,0,0,8},  // R8 writeback no stall
    '{1,0,0,0,0,0,0,0,0,0,6,6,1,0,0,1,0,9},  // R9 store data bypass
    '{0,0,0,0,0,0,0,0,0,0,6,6,1,0,0,0,0,7},  // R7 store bypass off
    '{1,0,0,0,0,0,1,1,0,0,0,0,0,0,0,0,0,4},  // R4 load to register 0
    '{1,5,0,0,0,5,0,1,0,0,0,0,0,0,0,0,0,4},  // R4 bubble: load flag, no write
    '{1,0,0,5,0,0,0,0,0,0,0,5,1,2,0,0,0,2}   // R2 writeback bypass A
  };

  // Bench model of pipeline stage contents
  typedef struct packed { logic [4:0] a, b, d; logic wr, ld, dep; } ins_t;
  localparam ins_t NOP = '0;

  task automatic drive(input ins_t id, input ins_t ex, input ins_t mem, input ins_t wb);
    id_src_a = id.a; id_src_b = id.b;
    ex_src_a = ex.a; ex_src_b = ex.b; ex_dst = ex.d; ex_wr = ex.wr; ex_load = ex.ld;
    mem_dst = mem.d; mem_wr = mem.wr; mem_store_src = mem.b;
    wb_dst = wb.d; wb_wr = wb.wr;
  endtask

  // R10: run producer then consumer through the modelled pipeline
  task automatic run_pair(input logic fwd, input logic prod_ld, input int exp_stalls,
                          input int exp_sel, input string what);
    ins_t id_q, ex_q, mem_q, wb_q, nxt;
    int stalls = 0;
    int sel_seen = -1;
    int pc = 1;
    fwd_en = fwd;
    id_q = '{a:5'd1, b:5'd2, d:5'd8, wr:1'b1, ld:prod_ld, dep:1'b0};
    nxt  = '{a:5'd8, b:5'd3, d:5'd9, wr:1'b1, ld:1'b0,   dep:1'b1};
    ex_q = NOP; mem_q = NOP; wb_q = NOP;
    for (int cyc = 0; cyc < 9; cyc++) begin
      drive(id_q, ex_q, mem_q, wb_q);
      #1;
      if (ex_q.dep && sel_seen < 0) sel_seen = int'(ex_sel_a);
      if (hold_fd) begin
        stalls++;
        wb_q = mem_q; mem_q = ex_q; ex_q = NOP;   // bubble clears all flags
      end else begin
        wb_q = mem_q; mem_q = ex_q; ex_q = id_q;
        id_q = (pc == 1) ? nxt : NOP;
        pc++;
      end
      @(posedge clk); #1;
    end
    check(10, {what, " stall cycles"}, stalls, exp_stalls);
    check(10, {what, " execute select"}, sel_seen, exp_sel);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    @(posedge clk); #1;
    // Idle state: all-zero fields give all-quiet outputs (R4)
    check(4, "idle sel a", ex_sel_a, 0);
    check(4, "idle hold", hold_fd, 0);
    check(5, "idle bubble", bubble_ex, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      fwd_en = v.fwd; id_src_a = v.ida; id_src_b = v.idb;
      ex_src_a = v.exa; ex_src_b = v.exb; ex_dst = v.exd; ex_wr = v.exwr; ex_load = v.exld;
      mem_dst = v.memd; mem_wr = v.memwr; mem_store_src = v.mst;
      wb_dst = v.wbd; wb_wr = v.wbwr;
      #1;
      check(int'(v.req), $sformatf("vec %0d sel a", i), ex_sel_a, v.sa);
      check(int'(v.req), $sformatf("vec %0d sel b", i), ex_sel_b, v.sb);
      check(int'(v.req), $sformatf("vec %0d store sel", i), mem_sel_store, v.ms);
      check(int'(v.req), $sformatf("vec %0d hold", i), hold_fd, v.st);
      check(int'(v.req), $sformatf("vec %0d bubble", i), bubble_ex, v.st);
      @(posedge clk); #1;
    end

    // R10 sequences: ALU/load producer, bypass on/off
    run_pair(1'b0, 1'b0, 2, 0, "nofwd alu");
    run_pair(1'b0, 1'b1, 2, 0, "nofwd load");
    run_pair(1'b1, 1'b0, 0, 1, "fwd alu");
    run_pair(1'b1, 1'b1, 1, 2, "fwd load");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule